// File: doc/BRIEF.md
# Dual-Input Up/Down Counter with Cascade Outputs

This block is a synchronous binary counter that has two count inputs in place of one clock and a direction pin. A rising edge on the up input adds one to the count. A rising edge on the down input subtracts one. In both cases the other input has to be resting high. Both count inputs are sampled on a single system clock, and every state bit updates on the same clock edge, so the count never shows a half-changed value.

An active-low load copies the preset word into the count. An active-high clear forces the count to zero. Both act at level on each system clock edge, and clear takes priority over load. Load and clear both take priority over counting.

Two active-low outputs, carry and borrow, are built for chaining stages. Carry is low while the up input is low and the count is at its maximum. Borrow is low while the down input is low and the count is zero. Each output therefore reproduces the low phase of the pulse that is about to wrap the count. When carry drives the next stage's up input and borrow drives its down input, a chain of stages counts with no glue logic. Loading a start value before counting lets a stage divide its input pulse train by a chosen modulus.

The block has no data stream, so it has no valid/ready handshake. All of its pins are plain control and status signals.

Top module: `updn_dual_counter`

## Requirements
- R1: After reset, with both count inputs high, the count is 0 and both carry_n_o and borrow_n_o are 1.
- R2: A low-to-high change on cnt_up_i while cnt_dn_i stays high raises the count by one. The new count is visible after the first system clock edge that samples cnt_up_i high.
- R3: A low-to-high change on cnt_dn_i while cnt_up_i stays high lowers the count by one, with the same timing as R2.
- R4: The count holds when both count inputs rise in the same clock cycle. It also holds when a count input rises while the other input is low, and while a count input simply stays low.
- R5: When clear_i is 1, the next clock edge sets the count to 0. This happens whatever load_n_i, preset_i and the count inputs are doing.
- R6: When load_n_i is 0 and clear_i is 0, the next clock edge copies preset_i into the count. Bit i of preset_i goes to bit i of the count, and count-input edges during that cycle are ignored.
- R7: Counting wraps modulo 16. Counting up from 15 gives 0, and counting down from 0 gives 15.
- R8: carry_n_o is 0 exactly when cnt_up_i is 0 and the count is 15. Otherwise it is 1, and it follows the inputs with no clock delay.
- R9: borrow_n_o is 0 exactly when cnt_dn_i is 0 and the count is 0. Otherwise it is 1, and it follows the inputs with no clock delay.
- R10: In a chain where one stage's carry_n_o drives the next stage's cnt_up_i and its borrow_n_o drives the next stage's cnt_dn_i, the next stage steps up once when the first stage wraps from 15 to 0. It steps down once when the first stage wraps from 0 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_up_i | input | 1 | Up-count input; counts on its rising edge |
| cnt_dn_i | input | 1 | Down-count input; counts on its rising edge |
| load_n_i | input | 1 | Active-low parallel load |
| clear_i | input | 1 | Active-high clear, highest priority |
| preset_i | input | 4 | Preset word for load |
| count_o | output | 4 | Current count |
| carry_n_o | output | 1 | Active-low carry for cascading |
| borrow_n_o | output | 1 | Active-low borrow for cascading |

## Verification
The hardest case to reach is the wrap of a chained stage. That is the only point where the second stage's count input is driven by the first stage's combinational carry or borrow. The carry or borrow edge has to line up with the first stage's own count step. The bench instantiates two stages with the first stage's carry and borrow wired to the second stage's count inputs. It loads the first stage to 15 and pulses its up input, then pulses its down input from 0. It then checks that the second stage took exactly one step each time.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic [2:0] {
    ACT_HOLD  = 3'd0,
    ACT_CLEAR = 3'd1,
    ACT_LOAD  = 3'd2,
    ACT_INC   = 3'd3,
    ACT_DEC   = 3'd4
  } act_e;
endpackage

// File: rtl/updn_edge_sampler.sv
module updn_edge_sampler #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  for (genvar g = 0; g < N; g++) begin : g_ch
    // idle level of a count input is high
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[g] <= 1'b1;
      else        prev_q[g] <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~prev_q[g];
  end
endmodule

// File: rtl/updn_step_ctrl.sv
module updn_step_ctrl
  import updn_pkg::*;
(
  input  logic clear_i,
  input  logic load_n_i,
  input  logic up_lvl_i,
  input  logic dn_lvl_i,
  input  logic up_rise_i,
  input  logic dn_rise_i,
  output act_e act_o
);
  always_comb begin
    act_o = ACT_HOLD;
    if (clear_i)                                    act_o = ACT_CLEAR;
    else if (!load_n_i)                             act_o = ACT_LOAD;
    else if (up_rise_i && !dn_rise_i && dn_lvl_i)   act_o = ACT_INC;
    else if (dn_rise_i && !up_rise_i && up_lvl_i)   act_o = ACT_DEC;
  end
endmodule

// File: rtl/updn_state_reg.sv
module updn_state_reg
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  act_e             act_i,
  input  logic [WIDTH-1:0] preset_i,
  output logic [WIDTH-1:0] count_o
);
  logic [WIDTH-1:0] nxt;

  always_comb begin
    case (act_i)
      ACT_CLEAR: nxt = '0;
      ACT_LOAD:  nxt = preset_i;
      ACT_INC:   nxt = count_o + WIDTH'(1);
      ACT_DEC:   nxt = count_o - WIDTH'(1);
      default:   nxt = count_o;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_o <= '0;
    else        count_o <= nxt;
  end
endmodule

// File: rtl/updn_terminal.sv
module updn_terminal #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] count_i,
  input  logic             up_lvl_i,
  input  logic             dn_lvl_i,
  output logic             carry_n_o,
  output logic             borrow_n_o
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  assign carry_n_o  = ~(~up_lvl_i & (count_i == TOP));
  assign borrow_n_o = ~(~dn_lvl_i & (count_i == '0));
endmodule

// File: rtl/updn_dual_counter.sv
module updn_dual_counter
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_up_i,
  input  logic             cnt_dn_i,
  input  logic             load_n_i,
  input  logic             clear_i,
  input  logic [WIDTH-1:0] preset_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_n_o,
  output logic             borrow_n_o
);
  localparam int NCH = 2;
  localparam int UP  = 0;
  localparam int DN  = 1;

  logic [NCH-1:0] lvl, rise;
  act_e           act;

  assign lvl[UP] = cnt_up_i;
  assign lvl[DN] = cnt_dn_i;

  updn_edge_sampler #(.N(NCH)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .rise_o(rise)
  );

  updn_step_ctrl u_ctrl (
    .clear_i(clear_i), .load_n_i(load_n_i),
    .up_lvl_i(lvl[UP]), .dn_lvl_i(lvl[DN]),
    .up_rise_i(rise[UP]), .dn_rise_i(rise[DN]),
    .act_o(act)
  );

  updn_state_reg #(.WIDTH(WIDTH)) u_state (
    .clk(clk), .rst_n(rst_n), .act_i(act),
    .preset_i(preset_i), .count_o(count_o)
  );

  updn_terminal #(.WIDTH(WIDTH)) u_term (
    .count_i(count_o), .up_lvl_i(lvl[UP]), .dn_lvl_i(lvl[DN]),
    .carry_n_o(carry_n_o), .borrow_n_o(borrow_n_o)
  );
endmodule

// File: rtl/updn_dual_counter_chk.sv
module updn_dual_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_up_i,
  input logic             cnt_dn_i,
  input logic             load_n_i,
  input logic             clear_i,
  input logic [WIDTH-1:0] preset_i,
  input logic [WIDTH-1:0] count_o,
  input logic             carry_n_o,
  input logic             borrow_n_o
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  logic up_prev, dn_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_prev <= 1'b1;
      dn_prev <= 1'b1;
    end else begin
      up_prev <= cnt_up_i;
      dn_prev <= cnt_dn_i;
    end
  end

  logic up_ev, dn_ev, quiet;
  assign up_ev = cnt_up_i && !up_prev && cnt_dn_i && dn_prev;
  assign dn_ev = cnt_dn_i && !dn_prev && cnt_up_i && up_prev;
  assign quiet = !clear_i && load_n_i && !up_ev && !dn_ev;

  p_up_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && load_n_i && up_ev) |=> count_o == $past(count_o) + WIDTH'(1));

  p_dn_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && load_n_i && dn_ev) |=> count_o == $past(count_o) - WIDTH'(1));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> $stable(count_o));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> count_o == '0);

  p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !load_n_i) |=> count_o == $past(preset_i));

  p_carry_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o != TOP || cnt_up_i) |-> carry_n_o);

  p_borrow_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o != '0 || cnt_dn_i) |-> borrow_n_o);
endmodule

bind updn_dual_counter updn_dual_counter_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_updn_dual_counter.sv
`timescale 1ns/1ps
module sim_updn_dual_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up0 = 1'b1, dn0 = 1'b1, ld0 = 1'b1, ld1 = 1'b1, clr = 1'b0;
  logic [3:0] pre0 = 4'd0, pre1 = 4'd0;
  logic [3:0] q0, q1;
  logic c0, b0, c1, b1;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  updn_dual_counter #(.WIDTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_up_i(up0), .cnt_dn_i(dn0),
    .load_n_i(ld0), .clear_i(clr), .preset_i(pre0),
    .count_o(q0), .carry_n_o(c0), .borrow_n_o(b0)
  );

  updn_dual_counter #(.WIDTH(4)) u1 (
    .clk(clk), .rst_n(rst_n), .cnt_up_i(c0), .cnt_dn_i(b0),
    .load_n_i(ld1), .clear_i(clr), .preset_i(pre1),
    .count_o(q1), .carry_n_o(c1), .borrow_n_o(b1)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_up();
    @(negedge clk) up0 = 1'b0;
    @(negedge clk) up0 = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_dn();
    @(negedge clk) dn0 = 1'b0;
    @(negedge clk) dn0 = 1'b1;
    @(negedge clk);
  endtask

  task automatic load0(input logic [3:0] v);
    @(negedge clk) begin ld0 = 1'b0; pre0 = v; end
    @(negedge clk) ld0 = 1'b1;
  endtask

  task automatic t_reset();
    chk(q0 == 4'd0, "R1 count", int'(q0), 0);
    chk(c0 == 1'b1, "R1 carry", int'(c0), 1);
    chk(b0 == 1'b1, "R1 borrow", int'(b0), 1);
  endtask

  task automatic t_up();
    for (int i = 0; i < 3; i++) pulse_up();
    chk(q0 == 4'd3, "R2 up x3", int'(q0), 3);
  endtask

  task automatic t_down();
    pulse_dn();
    chk(q0 == 4'd2, "R3 down", int'(q0), 2);
  endtask

  task automatic t_hold();
    @(negedge clk) begin up0 = 1'b0; dn0 = 1'b0; end
    @(negedge clk) begin up0 = 1'b1; dn0 = 1'b1; end
    @(negedge clk);
    chk(q0 == 4'd2, "R4 both rise", int'(q0), 2);
    @(negedge clk) dn0 = 1'b0;
    pulse_up();
    chk(q0 == 4'd2, "R4 up while down low", int'(q0), 2);
    @(negedge clk) dn0 = 1'b1;   // this release is itself a down step
    @(negedge clk);
    chk(q0 == 4'd1, "R3 down on release", int'(q0), 1);
    @(negedge clk) up0 = 1'b0;
    repeat (5) @(negedge clk);
    chk(q0 == 4'd1, "R4 held low", int'(q0), 1);
    @(negedge clk) up0 = 1'b1;
    @(negedge clk);
    chk(q0 == 4'd2, "R2 step on release", int'(q0), 2);
  endtask

  task automatic t_load();
    @(negedge clk) begin ld0 = 1'b0; pre0 = 4'd10; up0 = 1'b0; end
    @(negedge clk) up0 = 1'b1;
    @(negedge clk);
    chk(q0 == 4'd10, "R6 load ignores count", int'(q0), 10);
    @(negedge clk) ld0 = 1'b1;
    @(negedge clk);
    chk(q0 == 4'd10, "R6 after release", int'(q0), 10);
    load0(4'd5);
    chk(q0 == 4'd5, "R6 load 5", int'(q0), 5);
  endtask

  task automatic t_clear();
    @(negedge clk) begin clr = 1'b1; ld0 = 1'b0; pre0 = 4'd9; up0 = 1'b0; end
    @(negedge clk) up0 = 1'b1;
    @(negedge clk);
    chk(q0 == 4'd0, "R5 clear wins", int'(q0), 0);
    @(negedge clk) begin clr = 1'b0; ld0 = 1'b1; end
    @(negedge clk);
    chk(q0 == 4'd0, "R5 after clear", int'(q0), 0);
  endtask

  task automatic t_wrap();
    load0(4'd15);
    pulse_up();
    chk(q0 == 4'd0, "R7 15 to 0", int'(q0), 0);
    pulse_dn();
    chk(q0 == 4'd15, "R7 0 to 15", int'(q0), 15);
  endtask

  task automatic t_term();
    load0(4'd15);
    @(negedge clk) up0 = 1'b0;
    #1 chk(c0 == 1'b0, "R8 carry low at 15", int'(c0), 0);
    chk(b0 == 1'b1, "R9 borrow idle at 15", int'(b0), 1);
    load0(4'd14);
    #1 chk(c0 == 1'b1, "R8 carry high at 14", int'(c0), 1);
    @(negedge clk) up0 = 1'b1;
    load0(4'd0);
    @(negedge clk) dn0 = 1'b0;
    #1 chk(b0 == 1'b0, "R9 borrow low at 0", int'(b0), 0);
    @(negedge clk) dn0 = 1'b1;
    #1 chk(b0 == 1'b1, "R9 borrow releases", int'(b0), 1);
    @(negedge clk);
  endtask

  task automatic t_cascade();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    load0(4'd15);
    chk(q1 == 4'd0, "R10 upper idle", int'(q1), 0);
    pulse_up();
    chk(q0 == 4'd0, "R10 lower wrap", int'(q0), 0);
    chk(q1 == 4'd1, "R10 upper up", int'(q1), 1);
    pulse_dn();
    chk(q0 == 4'd15, "R10 lower unwrap", int'(q0), 15);
    chk(q1 == 4'd0, "R10 upper down", int'(q1), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_up();
    t_down();
    t_hold();
    t_load();
    t_clear();
    t_wrap();
    t_term();
    t_cascade();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule